// File: doc/BRIEF.md
# Configurable UART Transmitter with RS-485 Direction Control

This block turns bytes from a ready/valid stream into asynchronous serial frames on a single transmit line. Three run-time inputs pick the frame format: the number of data bits, the parity mode and the stop length. A one-byte holding register sits in front of the serializer, so the next byte can wait while the current frame is on the line. Timing comes from an external divider. That divider sends a single-cycle `half_tick` pulse at twice the bit rate, and each bit lasts two of these pulses. Half-bit resolution is what makes a one-and-a-half-bit stop period possible.

The block also drives the direction pin of an RS-485 transceiver. The pin is active for the whole frame and for one more bit after the stop period, and its polarity is selectable. An active-low clear-to-send input is read only at frame boundaries, so a frame that has already started always finishes. A line-break request holds the line low for a programmable number of bits.

The state machine has seven states:
- IDLE: the line is high and the direction pin is inactive.
- START: the start bit.
- DATA: the data bits.
- PARITY: the parity bit.
- STOP: the stop period.
- TAIL: one extra bit with the line high and the direction pin still active.
- BREAK: the line is held low.

The transitions are:
- LAUNCH_BRK: IDLE or end of TAIL to BREAK.
- LAUNCH_DATA: IDLE or end of TAIL to START.
- TO_DATA: START to DATA.
- TO_PARITY: DATA to PARITY.
- TO_STOP: DATA or PARITY to STOP.
- TO_TAIL: STOP or BREAK to TAIL.
- TO_IDLE: TAIL to IDLE.

The launch decision is taken only on a half-tick. Every other transition happens on the half-tick that ends the state's last half-bit.

Top module: `uart_tx_rs485`

## Requirements
- R1: After reset `txd` is 1, `de` equals `cfg_de_low` (inactive) and `in_ready` is 1. Whenever no frame, break or tail is in progress, `txd` stays 1.
- R2: A frame starts only on a `half_tick`. It begins with one low start bit, followed by 5 + `cfg_len` data bits (`cfg_len` 0..3) sent least significant bit first. Every bit lasts exactly two half-tick intervals.
- R3: `cfg_par` selects the parity bit, which follows the last data bit:
  - 1 gives even parity (the bit makes the count of ones even).
  - 2 gives odd parity.
  - 3 gives a constant 1 (mark).
  - 4 gives a constant 0 (space).
  - 0, 5, 6 and 7 give no parity bit.
- R4: `cfg_stop` sets the stop period, during which the line is high:
  - 0 gives 2 half-ticks.
  - 1 gives 3 half-ticks, but only when `cfg_len` is 0; with any other length it gives 4.
  - 2 and 3 give 4 half-ticks.
- R5: `de` is active from the first half of the start bit (or of a break) until two half-ticks after the stop period (or break) ends, and is inactive otherwise. `de` is active-high when `cfg_de_low` is 0 and active-low when it is 1.
- R6: `cts_n` is sampled only at frame boundaries. While `cts_n` is 1 no new frame starts, even with a byte held. A frame already under way completes unchanged.
- R7: If `brk_req` is 1 at a frame boundary, `txd` goes low for 2 × `brk_bits` half-ticks, then returns high for a two-half-tick tail. `de` is active throughout. The break takes priority over a held byte and is not gated by `cts_n`.
- R8: The length, stop, parity and data values are captured when the frame launches. Changing the configuration inputs during a frame does not alter that frame.
- R9: `in_ready` is 0 while a byte is held. The held byte is released to the serializer on launch, which frees the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_tick | input | 1 | Single-cycle pulse at twice the bit rate |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can accept a byte |
| cfg_len | input | 2 | Data length code (bits = 5 + code) |
| cfg_stop | input | 2 | Stop length code |
| cfg_par | input | 3 | Parity mode code |
| cfg_de_low | input | 1 | 1 makes `de` active-low |
| cts_n | input | 1 | Clear to send, active low |
| brk_req | input | 1 | Line break request (level) |
| brk_bits | input | 8 | Break length in bit times |
| txd | output | 1 | Serial output, idle high |
| de | output | 1 | RS-485 direction enable |
| | | | |

## Verification
Every result of this block belongs to one half-tick interval. The state register moves on the clock edge where `half_tick` is high, and `txd` and `de` are decoded from that register with no further delay. The bench therefore waits for a rising edge that carries a tick, then reads both outputs on the following falling edge. This gives one sample per half-bit, which it compares with a stream built from the configuration. A byte launches on the first tick after it is accepted, so the bench aligns each frame by its first low sample. From that point every start, data, parity, stop and tail half-bit has a fixed index. The interval right after the tail must show the idle level.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_START  = 3'd1,
        S_DATA   = 3'd2,
        S_PARITY = 3'd3,
        S_STOP   = 3'd4,
        S_TAIL   = 3'd5,
        S_BREAK  = 3'd6
    } utx_state_e;

    localparam logic [2:0] PAR_EVEN  = 3'd1;
    localparam logic [2:0] PAR_ODD   = 3'd2;
    localparam logic [2:0] PAR_MARK  = 3'd3;
    localparam logic [2:0] PAR_SPACE = 3'd4;
endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            data <= in_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assign in_ready = !full;

    // R9
    hold_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/utx_parity.sv
module utx_parity import utx_pkg::*; #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_code,
    input  logic [2:0]        mode,
    output logic              par_en,
    output logic              par_bit
);
    localparam int MIN_BITS = 5;
    logic acc;

    always_comb begin
        acc = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < MIN_BITS + int'(len_code)) acc = acc ^ data[i];
        end
        par_en  = 1'b1;
        par_bit = 1'b0;
        unique case (mode)
            PAR_EVEN:  par_bit = acc;
            PAR_ODD:   par_bit = ~acc;
            PAR_MARK:  par_bit = 1'b1;
            PAR_SPACE: par_bit = 1'b0;
            default:   par_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/utx_fsm.sv
module utx_fsm import utx_pkg::*; #(
    parameter int DATA_W = 8,
    parameter int BRK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_stop,
    input  logic              par_en,
    input  logic              par_bit,
    input  logic              cts_n,
    input  logic              brk_req,
    input  logic [BRK_W-1:0]  brk_bits,
    output logic              txd,
    output logic              de_act
);
    localparam int CNT_W = BRK_W + 2;
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    utx_state_e        state_q, state_d;
    logic [CNT_W-1:0]  remain_q;
    logic [IDX_W-1:0]  idx_q, last_idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              lat_par_en_q, lat_par_bit_q;
    logic [2:0]        stop_h_q, stop_h_new;
    logic [1:0]        lat_len_q;
    logic              at_end, boundary, launch_brk, launch_dat;
    logic [BRK_W-1:0]  brk_eff;
    logic [CNT_W-1:0]  brk_load, stop_load;

    always_comb begin
        at_end     = (remain_q == '0);
        boundary   = half_tick && ((state_q == S_IDLE) || (state_q == S_TAIL && at_end));
        launch_brk = boundary && brk_req;
        launch_dat = boundary && !brk_req && hold_full && !cts_n;
        take       = launch_dat;
        brk_eff    = (brk_bits == '0) ? BRK_W'(1) : brk_bits;
        brk_load   = {1'b0, brk_eff, 1'b0} - CNT_W'(1);
        stop_load  = CNT_W'(stop_h_q) - CNT_W'(1);
        unique case (cfg_stop)
            2'd0:    stop_h_new = 3'd2;
            2'd1:    stop_h_new = (cfg_len == 2'd0) ? 3'd3 : 3'd4;
            default: stop_h_new = 3'd4;
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (launch_brk) begin
            state_d = S_BREAK;
        end else if (launch_dat) begin
            state_d = S_START;
        end else if (half_tick && at_end) begin
            unique case (state_q)
                S_IDLE:   state_d = S_IDLE;
                S_START:  state_d = S_DATA;
                S_DATA:   if (idx_q == last_idx_q)
                              state_d = lat_par_en_q ? S_PARITY : S_STOP;
                S_PARITY: state_d = S_STOP;
                S_STOP:   state_d = S_TAIL;
                S_BREAK:  state_d = S_TAIL;
                S_TAIL:   state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q      <= '0;
            idx_q         <= '0;
            last_idx_q    <= '0;
            shreg_q       <= '0;
            lat_par_en_q  <= 1'b0;
            lat_par_bit_q <= 1'b0;
            stop_h_q      <= 3'd2;
            lat_len_q     <= 2'd0;
        end else if (launch_dat) begin
            shreg_q       <= hold_data;
            idx_q         <= '0;
            last_idx_q    <= IDX_W'(4) + IDX_W'(cfg_len);
            remain_q      <= CNT_W'(1);
            lat_par_en_q  <= par_en;
            lat_par_bit_q <= par_bit;
            stop_h_q      <= stop_h_new;
            lat_len_q     <= cfg_len;
        end else if (launch_brk) begin
            remain_q <= brk_load;
        end else if (half_tick && state_q != S_IDLE) begin
            if (!at_end) begin
                remain_q <= remain_q - CNT_W'(1);
            end else begin
                unique case (state_q)
                    S_START: remain_q <= CNT_W'(1);
                    S_DATA: begin
                        if (idx_q != last_idx_q) begin
                            idx_q    <= idx_q + IDX_W'(1);
                            shreg_q  <= shreg_q >> 1;
                            remain_q <= CNT_W'(1);
                        end else begin
                            remain_q <= lat_par_en_q ? CNT_W'(1) : stop_load;
                        end
                    end
                    S_PARITY: remain_q <= stop_load;
                    S_STOP:   remain_q <= CNT_W'(1);
                    S_BREAK:  remain_q <= CNT_W'(1);
                    default:  remain_q <= remain_q;
                endcase
            end
        end
    end

    always_comb begin
        txd    = 1'b1;
        de_act = 1'b1;
        unique case (state_q)
            S_IDLE:   de_act = 1'b0;
            S_START:  txd = 1'b0;
            S_DATA:   txd = shreg_q[0];
            S_PARITY: txd = lat_par_bit_q;
            S_STOP:   txd = 1'b1;
            S_TAIL:   txd = 1'b1;
            S_BREAK:  txd = 1'b0;
            default:  de_act = 1'b0;
        endcase
    end

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> $past(half_tick));

    // R6
    cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && $past(state_q) != S_START) |-> !$past(cts_n));

    // R4
    half_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_h_q == 3'd3) |-> (lat_len_q == 2'd0));

    // R8
    par_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_DATA || state_q == S_PARITY) &&
         ($past(state_q) == S_START || $past(state_q) == S_DATA || $past(state_q) == S_PARITY))
        |-> $stable(lat_par_bit_q));

    // R5
    tail_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAIL && $past(state_q) != S_TAIL)
        |-> ($past(state_q) == S_STOP || $past(state_q) == S_BREAK));
endmodule

// File: rtl/uart_tx_rs485.sv
module uart_tx_rs485 #(
    parameter int DATA_W = 8,
    parameter int BRK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              half_tick,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        cfg_len,
    input  logic [1:0]        cfg_stop,
    input  logic [2:0]        cfg_par,
    input  logic              cfg_de_low,
    input  logic              cts_n,
    input  logic              brk_req,
    input  logic [BRK_W-1:0]  brk_bits,
    output logic              txd,
    output logic              de
);
    logic              hold_full, take, par_en, par_bit, de_act;
    logic [DATA_W-1:0] hold_data;

    utx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .take(take), .full(hold_full), .data(hold_data)
    );

    utx_parity #(.DATA_W(DATA_W)) u_par (
        .data(hold_data), .len_code(cfg_len), .mode(cfg_par),
        .par_en(par_en), .par_bit(par_bit)
    );

    utx_fsm #(.DATA_W(DATA_W), .BRK_W(BRK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .hold_full(hold_full), .hold_data(hold_data), .take(take),
        .cfg_len(cfg_len), .cfg_stop(cfg_stop), .par_en(par_en), .par_bit(par_bit),
        .cts_n(cts_n), .brk_req(brk_req), .brk_bits(brk_bits),
        .txd(txd), .de_act(de_act)
    );

    assign de = de_act ^ cfg_de_low;

    // R5
    de_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!txd) |-> (de != cfg_de_low));
endmodule

// File: tb/sim_uart_tx_rs485.sv
module sim_uart_tx_rs485;
    localparam int CLK_NS   = 10;
    localparam int TICK_DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_stop = 2'd0;
    logic [2:0] cfg_par = 3'd0;
    logic       cfg_de_low = 1'b0;
    logic       cts_n = 1'b0;
    logic       brk_req = 1'b0;
    logic [7:0] brk_bits = 8'd2;
    logic       txd, de;

    int vecs = 0;
    int fails = 0;
    int tcnt = 0;

    bit    exp_tx [0:63];
    string exp_tag[0:63];
    int    exp_n;

    uart_tx_rs485 u0 (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_len(cfg_len), .cfg_stop(cfg_stop), .cfg_par(cfg_par),
        .cfg_de_low(cfg_de_low), .cts_n(cts_n), .brk_req(brk_req),
        .brk_bits(brk_bits), .txd(txd), .de(de)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        tcnt = (tcnt == TICK_DIV-1) ? 0 : tcnt + 1;
        half_tick = (tcnt == TICK_DIV-1);
    end

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic get_half(output bit t, output bit d);
        forever begin
            @(posedge clk);
            if (half_tick) break;
        end
        @(negedge clk);
        t = txd;
        d = de;
    endtask

    task automatic add(input bit v, input string tag, input int cnt);
        for (int k = 0; k < cnt; k++) begin
            exp_tx[exp_n] = v;
            exp_tag[exp_n] = tag;
            exp_n++;
        end
    endtask

    task automatic build_exp(input logic [7:0] b, input int len, input int stp, input int par);
        int  nbits;
        bit  ones;
        exp_n = 0;
        nbits = 5 + len;
        ones = 1'b0;
        add(1'b0, "R2 start", 2);
        for (int k = 0; k < nbits; k++) begin
            add(b[k], "R2 data", 2);
            ones = ones ^ b[k];
        end
        if (par == 1)      add(ones,  "R3 even", 2);
        else if (par == 2) add(~ones, "R3 odd", 2);
        else if (par == 3) add(1'b1,  "R3 mark", 2);
        else if (par == 4) add(1'b0,  "R3 space", 2);
        if (stp == 0)                 add(1'b1, "R4 stop", 2);
        else if (stp == 1 && len == 0) add(1'b1, "R4 stop", 3);
        else                          add(1'b1, "R4 stop", 4);
        add(1'b1, "R5 tail", 2);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_data = b;
        in_valid = 1'b1;
        do @(posedge clk); while (!in_ready);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // act: 0 plain, 1 change configuration mid-frame, 2 drop CTS and offer a second byte
    task automatic run_check(input int act, input logic [7:0] b2);
        bit t, d;
        int guard;
        guard = 0;
        t = 1'b1;
        while (t && guard < 40) begin
            get_half(t, d);
            guard++;
        end
        chk("R2 start seen", int'(t), 0);
        chk("R5 de at start", int'(d), int'(1'b1 ^ cfg_de_low));
        for (int i = 1; i < exp_n; i++) begin
            if (act == 1 && i == 1) begin
                cfg_len = 2'd0; cfg_par = 3'd3; cfg_stop = 2'd1;
            end
            if (act == 2 && i == 1) begin
                cts_n = 1'b1; in_data = b2; in_valid = 1'b1;
            end
            if (act == 2 && i == 3) in_valid = 1'b0;
            get_half(t, d);
            chk(act == 1 ? {"R8 ", exp_tag[i]} : exp_tag[i], int'(t), int'(exp_tx[i]));
            chk("R5 de active", int'(d), int'(1'b1 ^ cfg_de_low));
        end
        get_half(t, d);
        chk("R1 idle txd", int'(t), 1);
        chk("R5 de released", int'(d), int'(cfg_de_low));
    endtask

    task automatic quiet(input string tag, input int n);
        bit t, d;
        for (int i = 0; i < n; i++) begin
            get_half(t, d);
            chk(tag, int'(t), 1);
            chk(tag, int'(d), int'(cfg_de_low));
        end
    endtask

    task automatic break_check(input int nb);
        bit t, d;
        int guard;
        brk_bits = 8'(nb);
        brk_req = 1'b1;
        guard = 0;
        t = 1'b1;
        while (t && guard < 40) begin
            get_half(t, d);
            guard++;
        end
        brk_req = 1'b0;
        chk("R7 break start", int'(t), 0);
        chk("R7 de in break", int'(d), int'(1'b1 ^ cfg_de_low));
        for (int i = 1; i < 2*nb; i++) begin
            get_half(t, d);
            chk("R7 break low", int'(t), 0);
            chk("R7 de in break", int'(d), int'(1'b1 ^ cfg_de_low));
        end
        for (int i = 0; i < 2; i++) begin
            get_half(t, d);
            chk("R7 break tail", int'(t), 1);
            chk("R5 de in tail", int'(d), int'(1'b1 ^ cfg_de_low));
        end
        get_half(t, d);
        chk("R7 break idle", int'(t), 1);
        chk("R5 de after break", int'(d), int'(cfg_de_low));
    endtask

    initial begin
        #(CLK_NS * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset txd", int'(txd), 1);
        chk("R1 reset de", int'(de), 0);
        chk("R9 reset ready", int'(in_ready), 1);

        // R2 R3 R4 R5 sweep over every format code
        for (int ln = 0; ln < 4; ln++)
            for (int sp = 0; sp < 4; sp++)
                for (int pr = 0; pr < 8; pr++)
                    for (int bi = 0; bi < 2; bi++) begin
                        b = (bi == 1) ? (8'hA5 ^ 8'(ln*37 + sp*11 + pr*3)) : (8'h3C + 8'(pr*17 + ln));
                        cfg_len = 2'(ln); cfg_stop = 2'(sp); cfg_par = 3'(pr);
                        cfg_de_low = 1'((pr + sp + bi) % 2);
                        build_exp(b, ln, sp, pr);
                        push(b);
                        run_check(0, 8'h00);
                    end

        // R8 configuration changed mid-frame
        cfg_de_low = 1'b0;
        cfg_len = 2'd3; cfg_stop = 2'd0; cfg_par = 3'd1;
        build_exp(8'h96, 3, 0, 1);
        push(8'h96);
        run_check(1, 8'h00);

        // R6 held byte waits while CTS is inactive, R9 ready stays low
        cfg_len = 2'd3; cfg_stop = 2'd0; cfg_par = 3'd0;
        cts_n = 1'b1;
        push(8'h5A);
        quiet("R6 no launch", 30);
        chk("R9 ready while held", int'(in_ready), 0);
        cts_n = 1'b0;
        build_exp(8'h5A, 3, 0, 0);
        run_check(0, 8'h00);

        // R6 CTS dropped mid-frame: frame completes, next byte withheld
        cfg_par = 3'd2;
        build_exp(8'hC3, 3, 0, 2);
        push(8'hC3);
        run_check(2, 8'h81);
        quiet("R6 second byte withheld", 30);
        chk("R9 second byte held", int'(in_ready), 0);
        cts_n = 1'b0;
        build_exp(8'h81, 3, 0, 2);
        run_check(0, 8'h00);

        // R7 break while CTS inactive and a byte is held, active-low enable
        cfg_de_low = 1'b1;
        cts_n = 1'b1;
        push(8'h42);
        break_check(3);
        chk("R7 byte still held", int'(in_ready), 0);
        cts_n = 1'b0;
        build_exp(8'h42, 3, 0, 2);
        run_check(0, 8'h00);
        cfg_de_low = 1'b0;
        break_check(1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule